// File: doc/BRIEF.md
# Competitive Snoop Update Counter Bank

This block tracks, for every line of a small cache, how many bus updates from other caches have arrived since the local processor last used that line. It serves a hybrid protocol that mostly keeps shared copies up to date through bus updates. When a line keeps receiving remote updates and the local processor stops touching it, the copy drops itself after a set number of unanswered updates. It does not stay valid and keep absorbing traffic.

Each line has a down-counter. A fill loads the counter with a threshold given at run time. Every snooped update aimed at the line lowers the counter by one. Any local read or write brings it back to the threshold. When the counter reaches zero, the line clears its valid bit and the block emits a one-cycle invalidate pulse with the line index.

A local write to a shared line asks for a bus update. If the shared response shows that no other cache still holds the line, the line moves to the modified state and stops asking for updates. The block keeps no data. It keeps only valid, modified and counter state.

Top module: `csnp_ctr_bank`

## Requirements
- R1: While reset is asserted and after it is released, every line is invalid and unmodified, and the invalidate pulse is low.
- R2: A fill to a line makes it valid and unmodified from the next clock edge, and loads its counter with the effective threshold.
- R3: Each snooped update to a valid line lowers its counter by one. The line stays valid while the counter is above zero.
- R4: The update that brings a counter to zero clears the line's valid (and modified) bit at the next edge. In that same cycle the invalidate output is high for exactly one cycle, with the index of that line.
- R5: A local read or write to a valid line reloads its counter with the effective threshold.
- R6: When a local access and a snooped update hit the same valid line in one cycle, the reload wins and the update has no effect.
- R7: The effective threshold is the threshold input (1 to 15) sampled at the fill or access. A threshold input of 0 behaves as 1.
- R8: A snooped update to an invalid line is ignored. The counter does not wrap below zero, no pulse is produced and no valid bit changes.
- R9: A local write to a valid, unmodified line raises the update-request output in the same cycle. If the shared input is low in that cycle, the line is modified from the next edge. If the shared input is high, the line stays unmodified.
- R10: A local write to a modified line raises no update request, and the line stays modified.
- R11: A fill and a snooped update to the same line in the same cycle load the line as for a fill alone.
- R12: A local access to an invalid line changes no state and raises no update request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh_i | input | CNT_W | Runtime update threshold (0 treated as 1) |
| fill_vld_i | input | 1 | Line fill strobe |
| fill_idx_i | input | IDX_W | Index of filled line |
| acc_vld_i | input | 1 | Local access strobe |
| acc_wr_i | input | 1 | Local access is a write |
| acc_idx_i | input | IDX_W | Index of accessed line |
| snp_vld_i | input | 1 | Snooped bus update strobe |
| snp_idx_i | input | IDX_W | Index of line targeted by the snooped update |
| shared_i | input | 1 | Shared response for this cycle's local write update |
| upd_req_o | output | 1 | Local write needs a bus update broadcast |
| inv_vld_o | output | 1 | One-cycle self-invalidate pulse |
| inv_idx_o | output | IDX_W | Index of the self-invalidated line |
| line_valid_o | output | N_LINES | Per-line valid bits |
| line_mod_o | output | N_LINES | Per-line modified bits |

## Verification
On every cycle, the bound checker confirms the following. A valid bit only falls together with a matching invalidate pulse. A pulse always points to a line that is now invalid. A fill always leaves its line valid. A modified bit is set only after a write that saw no sharer, and never sits on an invalid line. The exact count of updates before expiry, the reload on access, the priority orders and the threshold clamp depend on hidden counter values. Only the bench's scenarios and its cycle-level reference model can show them.

// File: rtl/csnp_pkg.sv
package csnp_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHD = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  function automatic logic [3:0] clamp_thresh(input logic [3:0] t);
    return (t == 4'd0) ? 4'd1 : t;
  endfunction
endpackage

// File: rtl/csnp_idx_decode.sv
module csnp_idx_decode #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic               en_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [N_LINES-1:0] hit_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_dec
    assign hit_o[g] = en_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/csnp_line_ctr.sv
module csnp_line_ctr
  import csnp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             fill_hit_i,
  input  logic             acc_hit_i,
  input  logic             acc_wr_i,
  input  logic             snp_hit_i,
  input  logic             shared_i,
  output logic             valid_o,
  output logic             mod_o,
  output logic             expire_o,
  output logic             upd_req_o
);
  line_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ce;

  assign ce = fill_hit_i | acc_hit_i | snp_hit_i;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    expire_o  = 1'b0;
    upd_req_o = 1'b0;
    if (fill_hit_i) begin
      st_d  = LN_SHD;
      cnt_d = thr_i;
    end else if (st_q != LN_INV) begin
      if (acc_hit_i) begin
        cnt_d = thr_i;
        if (acc_wr_i && st_q == LN_SHD) begin
          upd_req_o = 1'b1;
          if (!shared_i) st_d = LN_MOD;
        end
      end else if (snp_hit_i) begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_d    = '0;
          st_d     = LN_INV;
          expire_o = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_INV;
      cnt_q <= '0;
    end else if (ce) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign valid_o = (st_q != LN_INV);
  assign mod_o   = (st_q == LN_MOD);
endmodule

// File: rtl/csnp_expire_enc.sv
module csnp_expire_enc #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] exp_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (exp_i[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
  assign any_o = |exp_i;
endmodule

// File: rtl/csnp_ctr_bank.sv
module csnp_ctr_bank
  import csnp_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int CNT_W   = 4,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   thresh_i,
  input  logic               fill_vld_i,
  input  logic [IDX_W-1:0]   fill_idx_i,
  input  logic               acc_vld_i,
  input  logic               acc_wr_i,
  input  logic [IDX_W-1:0]   acc_idx_i,
  input  logic               snp_vld_i,
  input  logic [IDX_W-1:0]   snp_idx_i,
  input  logic               shared_i,
  output logic               upd_req_o,
  output logic               inv_vld_o,
  output logic [IDX_W-1:0]   inv_idx_o,
  output logic [N_LINES-1:0] line_valid_o,
  output logic [N_LINES-1:0] line_mod_o
);
  logic [CNT_W-1:0]   thr_eff;
  logic [N_LINES-1:0] fill_hit, acc_hit, snp_hit, expire, upd_req;
  logic               exp_any, inv_vld_d;
  logic [IDX_W-1:0]   exp_idx, inv_idx_d;
  logic               inv_vld_q;
  logic [IDX_W-1:0]   inv_idx_q;

  assign thr_eff = (thresh_i == '0) ? CNT_W'(1) : thresh_i;

  csnp_idx_decode #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_dec_fill (
    .en_i(fill_vld_i), .idx_i(fill_idx_i), .hit_o(fill_hit));
  csnp_idx_decode #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_dec_acc (
    .en_i(acc_vld_i), .idx_i(acc_idx_i), .hit_o(acc_hit));
  csnp_idx_decode #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_dec_snp (
    .en_i(snp_vld_i), .idx_i(snp_idx_i), .hit_o(snp_hit));

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    csnp_line_ctr #(.CNT_W(CNT_W)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .thr_i      (thr_eff),
      .fill_hit_i (fill_hit[g]),
      .acc_hit_i  (acc_hit[g]),
      .acc_wr_i   (acc_wr_i),
      .snp_hit_i  (snp_hit[g]),
      .shared_i   (shared_i),
      .valid_o    (line_valid_o[g]),
      .mod_o      (line_mod_o[g]),
      .expire_o   (expire[g]),
      .upd_req_o  (upd_req[g])
    );
  end

  csnp_expire_enc #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_enc (
    .exp_i(expire), .any_o(exp_any), .idx_o(exp_idx));

  always_comb begin
    inv_vld_d = exp_any;
    inv_idx_d = exp_any ? exp_idx : inv_idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_vld_q <= 1'b0;
      inv_idx_q <= '0;
    end else begin
      inv_vld_q <= inv_vld_d;
      inv_idx_q <= inv_idx_d;
    end
  end

  assign inv_vld_o = inv_vld_q;
  assign inv_idx_o = inv_idx_q;
  assign upd_req_o = |upd_req;
endmodule

// File: rtl/csnp_ctr_bank_chk.sv
module csnp_ctr_bank_chk #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fill_vld_i,
  input logic [IDX_W-1:0]   fill_idx_i,
  input logic               acc_vld_i,
  input logic               acc_wr_i,
  input logic [IDX_W-1:0]   acc_idx_i,
  input logic               snp_vld_i,
  input logic               shared_i,
  input logic               inv_vld_o,
  input logic [IDX_W-1:0]   inv_idx_o,
  input logic [N_LINES-1:0] line_valid_o,
  input logic [N_LINES-1:0] line_mod_o
);
  a_r4_pulse_targets_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld_o |-> !line_valid_o[inv_idx_o]);

  a_r8_pulse_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld_o |-> $past(snp_vld_i));

  a_r2_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld_i |=> line_valid_o[$past(fill_idx_i)] && !line_mod_o[$past(fill_idx_i)]);

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    a_r4_fall_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_valid_o[g]) |-> (inv_vld_o && inv_idx_o == IDX_W'(g)));

    a_r9_mod_after_unshared_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_mod_o[g]) |-> $past(acc_vld_i && acc_wr_i && !shared_i && acc_idx_i == IDX_W'(g)));

    a_r1_mod_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
      line_mod_o[g] |-> line_valid_o[g]);
  end
endmodule

bind csnp_ctr_bank csnp_ctr_bank_chk #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_vld_i(fill_vld_i), .fill_idx_i(fill_idx_i),
  .acc_vld_i(acc_vld_i), .acc_wr_i(acc_wr_i), .acc_idx_i(acc_idx_i),
  .snp_vld_i(snp_vld_i), .shared_i(shared_i), .inv_vld_o(inv_vld_o),
  .inv_idx_o(inv_idx_o), .line_valid_o(line_valid_o), .line_mod_o(line_mod_o));

// File: tb/csnp_ctr_bank_test.sv
module csnp_ctr_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int IW = 3;

  logic          clk, rst_n;
  logic [3:0]    thresh;
  logic          fill_vld, acc_vld, acc_wr, snp_vld, shared;
  logic [IW-1:0] fill_idx, acc_idx, snp_idx;
  logic          upd_req, inv_vld;
  logic [IW-1:0] inv_idx;
  logic [NL-1:0] lval, lmod;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_cnt[NL];
  bit m_v[NL];
  bit m_m[NL];
  bit m_inv;
  int m_inv_idx;

  csnp_ctr_bank #(.N_LINES(NL), .CNT_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .thresh_i(thresh),
    .fill_vld_i(fill_vld), .fill_idx_i(fill_idx),
    .acc_vld_i(acc_vld), .acc_wr_i(acc_wr), .acc_idx_i(acc_idx),
    .snp_vld_i(snp_vld), .snp_idx_i(snp_idx), .shared_i(shared),
    .upd_req_o(upd_req), .inv_vld_o(inv_vld), .inv_idx_o(inv_idx),
    .line_valid_o(lval), .line_mod_o(lmod));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] pack_v();
    logic [NL-1:0] r;
    for (int i = 0; i < NL; i++) r[i] = m_v[i];
    return r;
  endfunction

  function automatic logic [NL-1:0] pack_m();
    logic [NL-1:0] r;
    for (int i = 0; i < NL; i++) r[i] = m_m[i];
    return r;
  endfunction

  task automatic cyc(input bit f, input int fi, input bit a, input int ai, input bit w,
                     input bit s, input int si, input bit sh, input int thr, input string tag);
    int  te;
    bit  exp_req;
    fill_vld = f; fill_idx = IW'(fi);
    acc_vld = a;  acc_idx = IW'(ai); acc_wr = w;
    snp_vld = s;  snp_idx = IW'(si);
    shared = sh;  thresh = 4'(thr);
    #1;
    exp_req = a && w && m_v[ai] && !m_m[ai] && !(f && fi == ai);
    chk({tag, " upd_req"}, int'(upd_req), int'(exp_req));
    @(posedge clk);
    te = (thr == 0) ? 1 : thr;
    m_inv = 0;
    for (int i = 0; i < NL; i++) begin
      if (f && fi == i) begin
        m_v[i] = 1; m_m[i] = 0; m_cnt[i] = te;
      end else if (m_v[i]) begin
        if (a && ai == i) begin
          m_cnt[i] = te;
          if (w && !m_m[i] && !sh) m_m[i] = 1;
        end else if (s && si == i) begin
          m_cnt[i] = m_cnt[i] - 1;
          if (m_cnt[i] == 0) begin
            m_v[i] = 0; m_m[i] = 0; m_inv = 1; m_inv_idx = i;
          end
        end
      end
    end
    @(negedge clk);
    chk({tag, " valid"}, int'(lval), int'(pack_v()));
    chk({tag, " mod"}, int'(lmod), int'(pack_m()));
    chk({tag, " inv_vld"}, int'(inv_vld), int'(m_inv));
    if (m_inv) chk({tag, " inv_idx"}, int'(inv_idx), m_inv_idx);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NL; i++) begin m_cnt[i] = 0; m_v[i] = 0; m_m[i] = 0; end
    m_inv = 0; m_inv_idx = 0;
    rst_n = 1'b0; fill_vld = 0; acc_vld = 0; acc_wr = 0; snp_vld = 0;
    fill_idx = '0; acc_idx = '0; snp_idx = '0; shared = 0; thresh = 4'd1;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(lval), 0);
    chk("R1 reset mod", int'(lmod), 0);
    chk("R1 reset inv", int'(inv_vld), 0);
    rst_n = 1'b1;
    idle(2, "R1 idle");

    // R2/R3/R4: fill with threshold 3, then three updates
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 3, "R2 fill");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 9, "R3 snoop1");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 9, "R3 snoop2");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 9, "R4 expire");
    idle(1, "R4 pulse one cycle");

    // R5: reload on local read
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 2, "R5 fill");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 2, "R5 snoop");
    cyc(0, 0, 1, 1, 0, 0, 0, 0, 2, "R5 reload");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 2, "R5 snoop after reload");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 2, "R5 expire after reload");

    // R6: access and update together
    cyc(1, 2, 0, 0, 0, 0, 0, 0, 2, "R6 fill");
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 2, 0, 1, 2, 0, 2, "R6 collide");
    cyc(0, 0, 0, 0, 0, 1, 2, 0, 2, "R6 snoop");
    cyc(0, 0, 0, 0, 0, 1, 2, 0, 2, "R6 expire");

    // R7: threshold zero acts as one
    cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R7 fill thr0");
    cyc(0, 0, 0, 0, 0, 1, 3, 0, 0, "R7 expire");
    cyc(1, 3, 0, 0, 0, 0, 0, 0, 15, "R7 fill thr15");
    for (int k = 0; k < 14; k++) cyc(0, 0, 0, 0, 0, 1, 3, 0, 1, "R7 thr15 snoop");
    cyc(0, 0, 0, 0, 0, 1, 3, 0, 1, "R7 thr15 expire");

    // R8: updates to an invalid line
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 1, 3, 0, 1, "R8 snoop invalid");
    cyc(1, 3, 0, 0, 0, 0, 0, 0, 2, "R8 refill");
    cyc(0, 0, 0, 0, 0, 1, 3, 0, 2, "R8 no wrap snoop");

    // R9/R10: write with and without sharers
    cyc(1, 4, 0, 0, 0, 0, 0, 0, 5, "R9 fill");
    cyc(0, 0, 1, 4, 1, 0, 0, 1, 5, "R9 write shared");
    cyc(0, 0, 1, 4, 1, 0, 0, 0, 5, "R9 write unshared");
    cyc(0, 0, 1, 4, 1, 0, 0, 0, 5, "R10 write modified");
    cyc(0, 0, 1, 4, 0, 0, 0, 1, 5, "R10 read modified");

    // R12: access to invalid line
    cyc(0, 0, 1, 5, 1, 0, 0, 0, 3, "R12 write invalid");
    cyc(0, 0, 1, 5, 0, 0, 0, 0, 3, "R12 read invalid");

    // R11: fill and update together
    cyc(1, 6, 0, 0, 0, 1, 6, 0, 1, "R11 fill+snoop");
    cyc(0, 0, 0, 0, 0, 1, 6, 0, 1, "R11 expire");

    // mixed traffic
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] & lfsr[5] & lfsr[9], int'(lfsr[3:1]), lfsr[4] & lfsr[11], int'(lfsr[8:6]),
          lfsr[10], lfsr[12] | lfsr[2], int'({lfsr[13], lfsr[1], lfsr[7]}), lfsr[14],
          int'(lfsr[15:12]), "RND R3 R5 R9 mix");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule